// File: doc/BRIEF.md
# Serial Gamma Setting Register Loader

This block gathers fixed-length serial words from a three-wire clock, data and strobe interface and turns each complete word into a write of a 10-bit setting. The setting goes into one of nineteen output registers: eighteen gamma tap levels and one common-electrode level. Each accepted word also carries an oscillator source flag, which the block holds and drives out. The three wires are asynchronous to the system clock. They pass through two-flop synchronisers, and the block detects their edges in the system clock domain. The serial clock may run at up to 5 MHz, well below the system clock.

A second write path serves an on-chip auto-read engine. That engine presents a whole 17-bit word in parallel together with a one-cycle load pulse. Words from both paths go through the same field checks before they reach the register bank. A one-cycle strobe marks every register update. The analog converter, the amplifiers and the oscillator sit outside this block. They consume the register contents and the oscillator flag.

Top module: `gl_loader`

## Requirements
- R1: While reset is high and on the first cycle after it, all nineteen settings read zero, the oscillator flag reads 0 and the write strobe is low.
- R2: A data bit is sampled on each rising edge of the serial clock while the strobe wire is low. A rising edge of the strobe wire commits the collected word to the addressed register. The write strobe pulses high for exactly one system cycle when that register changes.
- R3: Word layout in arrival order: bit 1 is a test bit, bit 2 is the oscillator flag (0 internal, 1 external), bits 3 to 7 are a 5-bit address sent MSB first, and bits 8 to 17 are a 10-bit value sent MSB first. Addresses 0 to 17 select the gamma taps, and address 18 selects the common level. Setting k appears on gamma_o[10k+9:10k].
- R4: If fewer than 17 bits arrived since the previous strobe-wire rise, the word is discarded: no register, flag or strobe changes.
- R5: If more than 17 bits arrived, only the last 17 received form the word.
- R6: A word whose test bit is 1 is ignored.
- R7: A word whose address is above 18 is ignored.
- R8: Every accepted word loads its oscillator flag bit into osc_ext_o. Ignored or discarded words leave the flag unchanged.
- R9: Each strobe-wire rise clears the bit count, whether or not the word was accepted, so bits of a dropped word never count toward the next one.
- R10: A pulse on ar_load_i submits ar_frame_i (bit 16 = test bit, bit 15 = flag, bits 14:10 = address, bits 9:0 = value) under the same checks. If a serial commit happens in the same cycle, the serial word is written and the auto-read word is dropped.
- R11: Serial clock edges that occur while the strobe wire is high are neither sampled nor counted.
- R12: The registers and the flag change only in a cycle where the write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial bit clock, asynchronous |
| sdin_i | input | 1 | Serial data, asynchronous |
| latch_i | input | 1 | Serial word strobe, asynchronous |
| ar_frame_i | input | 17 | Word from the auto-read engine |
| ar_load_i | input | 1 | One-cycle pulse submitting ar_frame_i |
| gamma_o | output | 190 | Nineteen 10-bit settings, setting k at [10k+9:10k] |
| osc_ext_o | output | 1 | Oscillator source flag, 1 = external |
| wr_stb_o | output | 1 | One-cycle pulse on each register update |

## Verification
The hardest case to reach from the ports is an auto-read pulse that lands in the very cycle the synchronised strobe-wire edge is detected. Only that coincidence exercises the arbitration between the two write paths. The stimulus changes the strobe wire on a falling system edge and counts two more falling edges to reach the detect cycle, then raises the auto-read pulse for exactly that cycle. The expected outcome is one strobe, with only the serial target changed. The saturating and clearing bit count is reached through sequences the ports allow: oversize words, back-to-back short words, and serial clock pulses given while the strobe wire is held high.

// File: rtl/gl_pkg.sv
package gl_pkg;
    localparam int FRAME_BITS = 17;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 10;
    localparam int NUM_REGS   = 19;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int BANK_W     = NUM_REGS * DATA_W;

    // Field order follows arrival order: the first bit lands in the MSB.
    typedef struct packed {
        logic              test;
        logic              osc;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_SERIAL = 2'd1,
        SRC_AUTO   = 2'd2
    } src_e;

    function automatic logic frame_ok(input frame_t f);
        return (f.test == 1'b0) && (int'(f.addr) < NUM_REGS);
    endfunction
endpackage

// File: rtl/gl_sync.sv
module gl_sync #(
    parameter int W = 3
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level_o = sync_q;
    assign rise_o  = sync_q & ~prev_q;
endmodule

// File: rtl/gl_shifter.sv
module gl_shifter
    import gl_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  bit_clk_rise_i,
    input  logic                  bit_i,
    input  logic                  latch_lvl_i,
    input  logic                  latch_rise_i,
    output logic [FRAME_BITS-1:0] frame_o,
    output logic                  full_o,
    output logic [CNT_W-1:0]      count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS);

    logic [FRAME_BITS-1:0] shift_q;
    logic [CNT_W-1:0]      cnt_q;
    logic                  take_bit;

    assign take_bit = bit_clk_rise_i && !latch_lvl_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shift_q <= '0;
        end else if (take_bit) begin
            shift_q <= {shift_q[FRAME_BITS-2:0], bit_i};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || latch_rise_i) begin
            cnt_q <= '0;
        end else if (take_bit && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign frame_o = shift_q;
    assign full_o  = (cnt_q == CNT_MAX);
    assign count_o = cnt_q;
endmodule

// File: rtl/gl_regbank.sv
module gl_regbank
    import gl_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wosc_i,
    output logic [BANK_W-1:0] bank_o,
    output logic              osc_o,
    output logic              stb_o
);
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        logic hit;
        assign hit = we_i && (waddr_i == ADDR_W'(k));
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                regs_q[k] <= '0;
            end else if (hit) begin
                regs_q[k] <= wdata_i;
            end
        end
        assign bank_o[k*DATA_W +: DATA_W] = regs_q[k];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            osc_o <= 1'b0;
            stb_o <= 1'b0;
        end else begin
            stb_o <= we_i;
            if (we_i) begin
                osc_o <= wosc_i;
            end
        end
    end
endmodule

// File: rtl/gl_loader.sv
module gl_loader
    import gl_pkg::*;
(
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      sclk_i,
    input  logic                      sdin_i,
    input  logic                      latch_i,
    input  logic [FRAME_BITS-1:0]     ar_frame_i,
    input  logic                      ar_load_i,
    output logic [BANK_W-1:0]         gamma_o,
    output logic                      osc_ext_o,
    output logic                      wr_stb_o
);
    localparam int IDX_CLK   = 0;
    localparam int IDX_DAT   = 1;
    localparam int IDX_LATCH = 2;

    logic [2:0]            pins_lvl;
    logic [2:0]            pins_rise;
    logic [FRAME_BITS-1:0] ser_frame;
    logic                  ser_full;
    logic [CNT_W-1:0]      bit_cnt;
    logic                  ser_commit;
    src_e                  src;
    frame_t                sel;
    logic                  accept;

    gl_sync #(.W(3)) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i ({latch_i, sdin_i, sclk_i}),
        .level_o (pins_lvl),
        .rise_o  (pins_rise)
    );

    gl_shifter u_shift (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .bit_clk_rise_i (pins_rise[IDX_CLK]),
        .bit_i          (pins_lvl[IDX_DAT]),
        .latch_lvl_i    (pins_lvl[IDX_LATCH]),
        .latch_rise_i   (pins_rise[IDX_LATCH]),
        .frame_o        (ser_frame),
        .full_o         (ser_full),
        .count_o        (bit_cnt)
    );

    assign ser_commit = pins_rise[IDX_LATCH] && ser_full;

    always_comb begin
        if (ser_commit) begin
            src = SRC_SERIAL;
            sel = frame_t'(ser_frame);
        end else if (ar_load_i) begin
            src = SRC_AUTO;
            sel = frame_t'(ar_frame_i);
        end else begin
            src = SRC_NONE;
            sel = '0;
        end
        accept = (src != SRC_NONE) && frame_ok(sel);
    end

    gl_regbank u_bank (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (accept),
        .waddr_i (sel.addr),
        .wdata_i (sel.data),
        .wosc_i  (sel.osc),
        .bank_o  (gamma_o),
        .osc_o   (osc_ext_o),
        .stb_o   (wr_stb_o)
    );
endmodule

// File: rtl/gl_loader_chk.sv
module gl_loader_chk
    import gl_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic [BANK_W-1:0] gamma_o,
    input logic              osc_ext_o,
    input logic              wr_stb_o,
    input logic              ser_commit,
    input logic              ar_load_i,
    input logic [CNT_W-1:0]  bit_cnt
);
    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (gamma_o == '0) && !osc_ext_o && !wr_stb_o); // R1

    AST_STROBE_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_stb_o |-> $past(ser_commit || ar_load_i)); // R2

    AST_BANK_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_stb_o |-> $stable(gamma_o)); // R12

    AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_stb_o |-> $stable(osc_ext_o)); // R8

    AST_COUNT_SATURATES: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_cnt <= CNT_W'(FRAME_BITS)); // R5

    AST_COUNT_CLEARED: assert property (@(posedge clk_i) disable iff (rst_i)
        ser_commit |=> bit_cnt == '0); // R9
endmodule

bind gl_loader gl_loader_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .gamma_o    (gamma_o),
    .osc_ext_o  (osc_ext_o),
    .wr_stb_o   (wr_stb_o),
    .ser_commit (ser_commit),
    .ar_load_i  (ar_load_i),
    .bit_cnt    (bit_cnt)
);

// File: tb/gl_loader_bench.sv
`timescale 1ns/1ps
module gl_loader_bench;
    localparam int NREG = 19;
    localparam int DW   = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        sdin = 1'b0;
    logic        latch = 1'b0;
    logic [16:0] ar_frame = '0;
    logic        ar_load = 1'b0;
    logic [NREG*DW-1:0] gamma;
    logic        osc;
    logic        stb;

    int checks = 0;
    int fails  = 0;
    int stb_cnt = 0;
    bit done = 0;
    logic [DW-1:0] exp_r [NREG];
    logic          exp_osc = 1'b0;

    always #10 clk = ~clk;

    gl_loader u_gl_loader (
        .clk_i      (clk),
        .rst_i      (rst),
        .sclk_i     (sclk),
        .sdin_i     (sdin),
        .latch_i    (latch),
        .ar_frame_i (ar_frame),
        .ar_load_i  (ar_load),
        .gamma_o    (gamma),
        .osc_ext_o  (osc),
        .wr_stb_o   (stb)
    );

    always @(posedge clk) if (!rst && stb) stb_cnt++;

    function automatic logic [16:0] mk(input logic t, input logic o,
                                       input logic [4:0] a, input logic [9:0] d);
        return {t, o, a, d};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_bank(input string req);
        int bad = -1;
        for (int k = 0; k < NREG; k++)
            if (gamma[k*DW +: DW] !== exp_r[k] && bad < 0) bad = k;
        checks++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s: reg %0d actual %0h expected %0h", req, bad,
                     gamma[bad*DW +: DW], exp_r[bad]);
        end
        check({req, " flag"}, 32'(osc), 32'(exp_osc));
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk) sdin = v[i];
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic pulse_latch();
        @(negedge clk) latch = 1'b1;
        repeat (8) @(negedge clk);
        latch = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        check_bank("R1 reset bank");
        check("R1 reset strobe", 32'(stb), 0);
    endtask

    task automatic t_write(input string req, input logic o, input int a, input logic [9:0] d);
        int s0 = stb_cnt;
        send_bits(32'(mk(1'b0, o, 5'(a), d)), 17);
        pulse_latch();
        exp_r[a] = d;
        exp_osc = o;
        check_bank(req);
        check({req, " one strobe"}, 32'(stb_cnt - s0), 1);
    endtask

    task automatic t_no_write(input string req, input logic [31:0] v, input int n);
        int s0 = stb_cnt;
        send_bits(v, n);
        pulse_latch();
        check_bank(req);
        check({req, " no strobe"}, 32'(stb_cnt - s0), 0);
    endtask

    task automatic t_long();
        int s0 = stb_cnt;
        send_bits(32'h1F, 5);
        send_bits(32'(mk(1'b0, 1'b0, 5'd7, 10'h155)), 17);
        pulse_latch();
        exp_r[7] = 10'h155;
        exp_osc = 1'b0;
        check_bank("R5 long word keeps last 17");
        check("R5 strobe", 32'(stb_cnt - s0), 1);
    endtask

    task automatic t_count_clear();
        int s0 = stb_cnt;
        send_bits(32'h2AB, 10);
        pulse_latch();
        send_bits(32'h155, 10);
        pulse_latch();
        check_bank("R9 count cleared per strobe");
        check("R9 no strobe", 32'(stb_cnt - s0), 0);
    endtask

    task automatic t_clk_while_latched();
        int s0 = stb_cnt;
        @(negedge clk) latch = 1'b1;
        sdin = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
        latch = 1'b0;
        repeat (8) @(negedge clk);
        send_bits(32'(mk(1'b0, 1'b1, 5'd3, 10'h3C3)) & 32'hFFF, 12);
        pulse_latch();
        check_bank("R11 edges while latched ignored");
        check("R11 no strobe", 32'(stb_cnt - s0), 0);
    endtask

    task automatic ar_pulse(input logic [16:0] f);
        @(negedge clk) ar_frame = f;
        ar_load = 1'b1;
        @(negedge clk) ar_load = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_auto();
        int s0 = stb_cnt;
        ar_pulse(mk(1'b0, 1'b1, 5'd9, 10'h0F0));
        exp_r[9] = 10'h0F0;
        exp_osc = 1'b1;
        check_bank("R10 auto-read write");
        check("R10 auto strobe", 32'(stb_cnt - s0), 1);
        s0 = stb_cnt;
        ar_pulse(mk(1'b1, 1'b0, 5'd9, 10'h001));
        ar_pulse(mk(1'b0, 1'b0, 5'd20, 10'h001));
        check_bank("R10 auto-read checks");
        check("R10 no strobe", 32'(stb_cnt - s0), 0);
    endtask

    task automatic t_collide();
        int s0 = stb_cnt;
        send_bits(32'(mk(1'b0, 1'b0, 5'd2, 10'h111)), 17);
        @(negedge clk) latch = 1'b1;
        @(negedge clk);
        @(negedge clk) ar_frame = mk(1'b0, 1'b1, 5'd4, 10'h222);
        ar_load = 1'b1;
        @(negedge clk) ar_load = 1'b0;
        repeat (6) @(negedge clk);
        latch = 1'b0;
        repeat (8) @(negedge clk);
        exp_r[2] = 10'h111;
        exp_osc = 1'b0;
        check_bank("R10 serial wins collision");
        check("R10 collision one strobe", 32'(stb_cnt - s0), 1);
    endtask

    initial begin
        for (int k = 0; k < NREG; k++) exp_r[k] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write("R2 R3 write tap 5", 1'b0, 5, 10'h2A5);
        t_write("R3 R8 common level", 1'b1, 18, 10'h3FF);
        t_write("R3 tap 0", 1'b1, 0, 10'h001);
        t_no_write("R4 short word", 32'(mk(1'b0, 1'b0, 5'd6, 10'h0AA)), 16);
        t_long();
        t_no_write("R6 test bit set", 32'(mk(1'b1, 1'b1, 5'd3, 10'h123)), 17);
        t_no_write("R7 address 19", 32'(mk(1'b0, 1'b1, 5'd19, 10'h123)), 17);
        t_no_write("R7 address 31", 32'(mk(1'b0, 1'b1, 5'd31, 10'h3FF)), 17);
        t_count_clear();
        t_clk_while_latched();
        t_auto();
        t_collide();
        t_write("R12 R8 tap 17 after all", 1'b1, 17, 10'h2C1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule